// File: doc/BRIEF.md
# Conditional Branch Decision Unit with Delay Slot

This block decides whether a branch instruction that issues in the current cycle is taken, and it computes where control goes. The decision is made from a 5-bit condition field and the zero, carry and negative flags. Each condition bit adds one constraint. The low two bits constrain the zero flag. The next two bits constrain one further flag, and the top bit chooses which one: carry or negative. A field with no bits set places no constraint, so it always branches. A field whose constraints contradict each other never branches.

Two target forms are supported. The relative form adds a signed 5-bit halfword offset to the address of the following instruction. The absolute form takes a register value, clears its lowest bit and keeps the address-width low bits.

The architecture has one delay slot. A taken branch does not redirect fetch at once. The target is held in a pending register, and the redirect is raised together with the next instruction that actually issues. Cycles without an issue leave the pending target in place.

Top module: `bu_branch_unit`

## Requirements
- R1: When an issuing branch has condition code 0, taken_o is 1 whatever the flags are.
- R2: Condition bit 0 set needs Z=0 and condition bit 1 set needs Z=1. When both bits are set, the branch is never taken.
- R3: Condition bit 4 selects the tested flag: N when it is 1, C when it is 0. Bit 2 set needs the selected flag clear and bit 3 set needs it set. When both bits 2 and 3 are set, the branch is never taken.
- R4: taken_o is 0 in any cycle in which issue_i or is_branch_i is 0.
- R5: With kind_i=0 (relative), target_o equals (pc_i + 2 + 2*sext(rel_off_i)) modulo 2^AW, where rel_off_i is a two's-complement value from -16 to +15.
- R6: With kind_i=1 (absolute), target_o equals reg_val_i[AW-1:0] with bit 0 forced to 0.
- R7: A taken branch never raises redirect_o in its own issue cycle. redirect_o is raised in the cycle of the next issued instruction, with redirect_pc_o equal to the target the branch presented.
- R8: In cycles with issue_i=0, redirect_o is 0, and both the pending redirect and redirect_pc_o are kept unchanged.
- R9: A pending redirect fires exactly once. After it fires, and after a not-taken branch, redirect_o stays 0 until another taken branch has issued.
- R10: After reset no redirect is pending, and the first issued instruction does not raise redirect_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | An instruction issues in this cycle |
| is_branch_i | input | 1 | The issuing instruction is a conditional branch |
| kind_i | input | 1 | 0 = relative target, 1 = absolute register target |
| cond_i | input | 5 | Condition field |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_n_i | input | 1 | Negative flag |
| pc_i | input | AW (24) | Address of the branch instruction |
| rel_off_i | input | 5 | Signed halfword offset for the relative form |
| reg_val_i | input | DW (32) | Register value for the absolute form |
| taken_o | output | 1 | The issuing branch is taken |
| target_o | output | AW (24) | Target computed for the issuing branch |
| redirect_o | output | 1 | Fetch must be redirected after this (delay-slot) instruction |
| redirect_pc_o | output | AW (24) | Pending redirect address |

## Verification
A fault in the condition decoder shows in the same cycle on taken_o, and only for the flag combinations that the faulty bit touches. The random mix therefore covers all 32 codes against all 8 flag patterns. A wrong pending bit shows on the next issue cycle: either a missing redirect after a taken branch, or a second, spurious redirect after the slot has fired. A target register that is lost or overwritten during stalls shows on redirect_pc_o at the delayed redirect. The directed sequences insert several stall cycles between the branch and its slot so that this case is covered.

// File: rtl/bu_pkg.sv
package bu_pkg;
  typedef enum logic {
    BK_REL = 1'b0,
    BK_ABS = 1'b1
  } br_kind_e;

  localparam int unsigned COND_W = 5;
  localparam int unsigned FLAG_W = 3;

  // flags packed as {n, c, z}
  function automatic logic cond_pass(input logic [COND_W-1:0] cc,
                                     input logic [FLAG_W-1:0] fl);
    logic zf;
    logic sel;
    logic ok;
    zf  = fl[0];
    sel = cc[4] ? fl[2] : fl[1];
    ok  = 1'b1;
    if (cc[0] && zf)   ok = 1'b0;
    if (cc[1] && !zf)  ok = 1'b0;
    if (cc[2] && sel)  ok = 1'b0;
    if (cc[3] && !sel) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/bu_cond_eval.sv
module bu_cond_eval
  import bu_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  logic              flag_z_i,
  input  logic              flag_c_i,
  input  logic              flag_n_i,
  output logic              met_o
);
  logic [FLAG_W-1:0] flag_idx;

  always_comb begin
    flag_idx = {flag_n_i, flag_c_i, flag_z_i};
    met_o    = cond_pass(cond_i, flag_idx);
  end
endmodule

// File: rtl/bu_target_gen.sv
module bu_target_gen
  import bu_pkg::*;
#(
  parameter int unsigned AW   = 24,
  parameter int unsigned DW   = 32,
  parameter int unsigned OFFW = 5
) (
  input  br_kind_e          kind_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [OFFW-1:0]   off_i,
  input  logic [DW-1:0]     reg_i,
  output logic [AW-1:0]     target_o
);
  localparam int unsigned EXT_W = AW - OFFW;

  logic [AW-1:0] rel_tgt;
  logic [AW-1:0] abs_tgt;

  function automatic logic [AW-1:0] rel_calc(input logic [AW-1:0] pc,
                                             input logic [OFFW-1:0] off);
    logic [AW-1:0] sx;
    sx = {{EXT_W{off[OFFW-1]}}, off};
    return pc + AW'(2) + (sx << 1);
  endfunction

  generate
    if (DW >= AW) begin : g_wide_reg
      function automatic logic [AW-1:0] abs_calc(input logic [DW-1:0] r);
        logic [DW-1:0] m;
        m = r & ~DW'(1);
        return m[AW-1:0];
      endfunction
      assign abs_tgt = abs_calc(reg_i);
    end else begin : g_narrow_reg
      function automatic logic [AW-1:0] abs_calc(input logic [DW-1:0] r);
        logic [AW-1:0] m;
        m = AW'(r);
        return m & ~AW'(1);
      endfunction
      assign abs_tgt = abs_calc(reg_i);
    end
  endgenerate

  assign rel_tgt  = rel_calc(pc_i, off_i);
  assign target_o = (kind_i == BK_ABS) ? abs_tgt : rel_tgt;
endmodule

// File: rtl/bu_redirect_reg.sv
module bu_redirect_reg #(
  parameter int unsigned AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic          load_i,
  input  logic [AW-1:0] load_tgt_i,
  output logic          redirect_o,
  output logic [AW-1:0] redirect_pc_o
);
  logic          pend_q;
  logic [AW-1:0] tgt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      tgt_q  <= '0;
    end else if (issue_i) begin
      pend_q <= load_i;
      if (load_i) tgt_q <= load_tgt_i;
    end
  end

  assign redirect_o    = pend_q & issue_i;
  assign redirect_pc_o = tgt_q;
endmodule

// File: rtl/bu_branch_unit.sv
module bu_branch_unit
  import bu_pkg::*;
#(
  parameter int unsigned AW = 24,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic          is_branch_i,
  input  logic          kind_i,
  input  logic [4:0]    cond_i,
  input  logic          flag_z_i,
  input  logic          flag_c_i,
  input  logic          flag_n_i,
  input  logic [AW-1:0] pc_i,
  input  logic [4:0]    rel_off_i,
  input  logic [DW-1:0] reg_val_i,
  output logic          taken_o,
  output logic [AW-1:0] target_o,
  output logic          redirect_o,
  output logic [AW-1:0] redirect_pc_o
);
  localparam int unsigned OFFW = 5;

  logic     cond_ok;
  logic     slot_load;
  br_kind_e kind;

  assign kind = br_kind_e'(kind_i);

  bu_cond_eval u_cond (
    .cond_i   (cond_i),
    .flag_z_i (flag_z_i),
    .flag_c_i (flag_c_i),
    .flag_n_i (flag_n_i),
    .met_o    (cond_ok)
  );

  bu_target_gen #(.AW(AW), .DW(DW), .OFFW(OFFW)) u_tgt (
    .kind_i   (kind),
    .pc_i     (pc_i),
    .off_i    (rel_off_i),
    .reg_i    (reg_val_i),
    .target_o (target_o)
  );

  assign slot_load = issue_i & is_branch_i & cond_ok;
  assign taken_o   = slot_load;

  bu_redirect_reg #(.AW(AW)) u_rdr (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue_i       (issue_i),
    .load_i        (slot_load),
    .load_tgt_i    (target_o),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o)
  );
endmodule

// File: rtl/bu_branch_unit_chk.sv
module bu_branch_unit_chk #(
  parameter int unsigned AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          issue_i,
  input logic          is_branch_i,
  input logic          kind_i,
  input logic [4:0]    cond_i,
  input logic          flag_z_i,
  input logic          flag_c_i,
  input logic          flag_n_i,
  input logic          taken_o,
  input logic [AW-1:0] target_o,
  input logic          redirect_o,
  input logic [AW-1:0] redirect_pc_o
);
  logic sel_flag;
  assign sel_flag = cond_i[4] ? flag_n_i : flag_c_i;

  p_always_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && is_branch_i && cond_i == 5'd0) |-> taken_o);

  p_zclr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i[0] && flag_z_i) |-> !taken_o);

  p_zset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i[1] && !flag_z_i) |-> !taken_o);

  p_fclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i[2] && sel_flag) |-> !taken_o);

  p_fset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i[3] && !sel_flag) |-> !taken_o);

  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_i || !is_branch_i) |-> !taken_o);

  p_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && kind_i) |-> !target_o[0]);

  p_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |=> (issue_i |-> (redirect_o && redirect_pc_o == $past(target_o))));

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |-> !redirect_o);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> $stable(redirect_pc_o));

  p_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !taken_o) |=> !redirect_o);
endmodule

bind bu_branch_unit bu_branch_unit_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .issue_i       (issue_i),
  .is_branch_i   (is_branch_i),
  .kind_i        (kind_i),
  .cond_i        (cond_i),
  .flag_z_i      (flag_z_i),
  .flag_c_i      (flag_c_i),
  .flag_n_i      (flag_n_i),
  .taken_o       (taken_o),
  .target_o      (target_o),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o)
);

// File: tb/sim_bu_branch_unit.sv
module sim_bu_branch_unit;
  localparam int CLK_P = 10;
  localparam int AW = 24;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          issue_i = 1'b0, is_branch_i = 1'b0, kind_i = 1'b0;
  logic [4:0]    cond_i = '0;
  logic          flag_z_i = 1'b0, flag_c_i = 1'b0, flag_n_i = 1'b0;
  logic [AW-1:0] pc_i = '0;
  logic [4:0]    rel_off_i = '0;
  logic [DW-1:0] reg_val_i = '0;
  logic          taken_o, redirect_o;
  logic [AW-1:0] target_o, redirect_pc_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  bit m_pend = 0;
  logic [AW-1:0] m_tgt = '0;

  always #(CLK_P/2) clk = ~clk;

  bu_branch_unit #(.AW(AW), .DW(DW)) u0 (.*);

  function automatic bit exp_cond(input logic [4:0] cc, input bit z, input bit c, input bit n);
    bit t = cc[4] ? n : c;
    if (cc[1:0] == 2'b11 || cc[3:2] == 2'b11) return 0;
    if (cc[0] && z != 0) return 0;
    if (cc[1] && z != 1) return 0;
    if (cc[2] && t != 0) return 0;
    if (cc[3] && t != 1) return 0;
    return 1;
  endfunction

  function automatic logic [AW-1:0] exp_tgt(input bit abs_k, input logic [AW-1:0] pc,
                                            input logic [4:0] off, input logic [DW-1:0] rv);
    int so;
    longint t;
    if (abs_k) return rv[AW-1:0] & 24'hFFFFFE;
    so = (off >= 5'd16) ? int'(off) - 32 : int'(off);
    t = longint'(pc) + 2 + 2 * so;
    return AW'(t & ((64'd1 << AW) - 1));
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit iss, input bit br, input bit k, input logic [4:0] cc,
                      input bit z, input bit c, input bit n, input logic [AW-1:0] pc,
                      input logic [4:0] off, input logic [DW-1:0] rv);
    bit et, er;
    logic [AW-1:0] eg;
    string tg;
    @(negedge clk);
    issue_i = iss; is_branch_i = br; kind_i = k; cond_i = cc;
    flag_z_i = z; flag_c_i = c; flag_n_i = n; pc_i = pc; rel_off_i = off; reg_val_i = rv;
    #1;
    et = iss && br && exp_cond(cc, z, c, n);
    eg = exp_tgt(k, pc, off, rv);
    er = m_pend && iss;
    if (!iss || !br) tg = "R4";
    else if (cc == 0) tg = "R1";
    else if (cc[1:0] != 0) tg = "R2";
    else tg = "R3";
    chk(tg, "taken", taken_o, et);
    chk(k ? "R6" : "R5", "target", target_o, eg);
    chk(er ? "R7" : (iss ? "R9" : "R8"), "redirect", redirect_o, er);
    if (er || (m_pend && !iss)) chk("R8", "redirect_pc", redirect_pc_o, m_tgt);
    if (iss) begin
      m_pend = et;
      if (et) m_tgt = eg;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R10: first issue after reset, no redirect
    step(1, 0, 0, 5'd0, 0, 0, 0, 24'h000100, 5'd0, 32'd0);
    // R1 always with flags all set
    step(1, 1, 0, 5'd0, 1, 1, 1, 24'h000200, 5'd3, 32'd0);
    step(1, 0, 0, 5'd0, 0, 0, 0, 24'h000202, 5'd0, 32'd0);
    // R2 contradictory z
    step(1, 1, 0, 5'd3, 0, 0, 0, 24'h000300, 5'd1, 32'd0);
    step(1, 1, 0, 5'd3, 1, 0, 0, 24'h000300, 5'd1, 32'd0);
    // R3 contradictory on C and N
    step(1, 1, 0, 5'd12, 0, 1, 0, 24'h000400, 5'd1, 32'd0);
    step(1, 1, 0, 5'd28, 0, 0, 1, 24'h000400, 5'd1, 32'd0);
    // R5 offset extremes and wrap
    step(1, 1, 0, 5'd0, 0, 0, 0, 24'h000010, 5'd16, 32'd0);
    step(1, 1, 0, 5'd0, 0, 0, 0, 24'hFFFFFE, 5'd15, 32'd0);
    // R6 absolute with odd value and upper bits, then stalls (R8)
    step(1, 1, 1, 5'd0, 0, 0, 0, 24'h000500, 5'd0, 32'hAB123457);
    step(0, 0, 0, 5'd0, 0, 0, 0, 24'h0, 5'd0, 32'd0);
    step(0, 1, 0, 5'd0, 0, 0, 0, 24'h0, 5'd0, 32'd0);
    step(0, 0, 0, 5'd0, 0, 0, 0, 24'h0, 5'd0, 32'd0);
    step(1, 0, 0, 5'd0, 0, 0, 0, 24'h000502, 5'd0, 32'd0);
    // R9 no second redirect
    step(1, 0, 0, 5'd0, 0, 0, 0, 24'h000504, 5'd0, 32'd0);
    // R7 branch in delay slot, both taken
    step(1, 1, 0, 5'd0, 0, 0, 0, 24'h000600, 5'd4, 32'd0);
    step(1, 1, 1, 5'd0, 0, 0, 0, 24'h000602, 5'd0, 32'h00001235);
    step(1, 0, 0, 5'd0, 0, 0, 0, 24'h001234, 5'd0, 32'd0);
    for (int i = 0; i < 4000; i++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 1),
           5'($urandom), $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
           24'($urandom), 5'($urandom), $urandom);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule